// File: doc/BRIEF.md
# Update-Triggered Compare Row Loader

This block refills the compare preload registers of a contiguous group of PWM channels once per timer update event. It takes duty words from a valid/ready stream that is ordered row by row. Each row holds one word for every selected channel, lowest channel first. Software, or a sequencer, selects a lowest and a highest channel and a number of rows, then issues a start pulse. From that point the block collects one row at a time into a staging buffer.

When an update event arrives and a complete row is waiting, the block writes the row into the preload registers. The writes go out one channel per cycle, in ascending channel order, over a shared data bus. Every update event also copies all preload registers into the active compare registers at once. A row written after update k therefore takes effect on all selected channels together at update k+1.

If a row is incomplete when an update arrives, nothing is written, the previous duties stay in force and a one-cycle underrun pulse is raised. After the programmed number of rows the block stops accepting words, drops its transfer enable and pulses done.

Top module: `cbl_burst_loader`

## Requirements
- R1: While reset is asserted and after it is released, s_ready, pre_we, xfer_en, underrun, done, ch_enable and cmp_active are all zero.
- R2: A seq_start pulse while xfer_en is low latches the channel range and row count. From the next cycle, ch_enable has bit c set exactly for the channels in the range, and xfer_en is high. A seq_start while xfer_en is high has no effect.
- R3: If ch_last is below ch_first, the range is the single channel ch_first.
- R4: s_ready is high only while xfer_en is high, no row write is in progress and the staging row holds fewer words than the range width.
- R5: An update event that finds a complete staged row starts a burst in the next cycle. The burst lasts one cycle per selected channel and pulses pre_we bit ch_first+k in cycle k, with pre_wdata carrying the k-th word of the row in arrival order.
- R6: On every update event, each channel's cmp_active field (bits c*DW+DW-1 down to c*DW) takes the value of its preload register. At all other times cmp_active holds. A row written after update k is therefore visible after update k+1.
- R7: An update event that finds the staged row incomplete writes nothing and raises underrun for exactly one cycle. The staged words are kept. A word accepted in the same cycle as the update event does not count toward the row.
- R8: The cycle after the last write of the final row, done is high for one cycle, while xfer_en and s_ready are low. A row count of zero gives a done pulse one cycle after the start pulse, with no writes.
- R9: At most one bit of pre_we is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_start | input | 1 | Start pulse for a sequence |
| seq_rows | input | RW | Number of rows in the sequence |
| ch_first | input | clog2(NCH) | Lowest selected channel |
| ch_last | input | clog2(NCH) | Highest selected channel |
| upd_evt | input | 1 | Timer update event pulse |
| s_valid | input | 1 | Duty word valid |
| s_data | input | DW | Duty word |
| s_ready | output | 1 | Duty word accepted when high with s_valid |
| pre_we | output | NCH | Preload write strobe, one bit per channel |
| pre_wdata | output | DW | Preload write data |
| cmp_active | output | NCH*DW | Active compare values, channel c in field c |
| ch_enable | output | NCH | Channel output enables set at start |
| xfer_en | output | 1 | Update-triggered transfer enabled |
| underrun | output | 1 | Update found an incomplete row |
| done | output | 1 | Sequence finished |

## Verification
The race of interest is the final word of a row arriving in the same cycle as an update event. The bench stages one word of a two-channel row, then drives the second word and the update pulse together on a single edge. It expects an underrun pulse and no preload write, then a full ascending burst of both words on the following update. A second concern is the update event that applies a row while the next row is still being staged. The bench judges this by comparing cmp_active immediately after each update against the row written in the previous burst.

// File: rtl/cbl_pkg.sv
`timescale 1ns/1ps
package cbl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2
  } cbl_state_e;
endpackage

// File: rtl/cbl_row_stage.sv
`timescale 1ns/1ps
module cbl_row_stage #(
  parameter int NCH = 4,
  parameter int DW  = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int LW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          accept_en,
  input  logic [LW-1:0] row_len,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  output logic          s_ready,
  output logic          row_full,
  input  logic [CW-1:0] rd_idx,
  output logic [DW-1:0] rd_word
);
  logic [LW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [DW-1:0] mem_q [NCH];
  logic          take;

  assign s_ready  = accept_en && (cnt_q < row_len);
  assign row_full = (cnt_q == row_len);
  assign take     = s_valid && s_ready;
  assign rd_word  = mem_q[rd_idx];

  always_comb begin
    cnt_en = clr || take;
    cnt_d  = cnt_q;
    if (clr)       cnt_d = '0;
    else if (take) cnt_d = cnt_q + LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = take && (cnt_q == LW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[i] <= '0;
      else if (slot_en) mem_q[i] <= s_data;
    end
  end
endmodule

// File: rtl/cbl_burst_seq.sv
`timescale 1ns/1ps
module cbl_burst_seq
  import cbl_pkg::*;
#(
  parameter int NCH = 4,
  parameter int RW  = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int LW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [RW-1:0] rows,
  input  logic [CW-1:0] first,
  input  logic [CW-1:0] last,
  input  logic          upd_evt,
  input  logic          row_full,
  output logic          accept_en,
  output logic          stage_clr,
  output logic [LW-1:0] row_len,
  output logic          wr_en,
  output logic [CW-1:0] wr_lane,
  output logic [CW-1:0] wr_idx,
  output logic [NCH-1:0] ch_mask,
  output logic          xfer_en,
  output logic          underrun,
  output logic          done
);
  cbl_state_e     state_q, state_d;
  logic [CW-1:0]  first_q, first_d;
  logic [LW-1:0]  len_q, len_d;
  logic [RW-1:0]  rows_q, rows_d;
  logic [CW-1:0]  k_q, k_d;
  logic [NCH-1:0] mask_q, mask_d;
  logic           unr_q, unr_d;
  logic           done_q, done_d;
  logic [LW-1:0]  span;
  logic [NCH-1:0] span_mask;

  always_comb begin
    if (last >= first) span = {1'b0, last} - {1'b0, first} + LW'(1);
    else               span = LW'(1);
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      span_mask[c] = (c >= int'(first)) && (c < int'(first) + int'(span));
    end
  end

  always_comb begin
    state_d   = state_q;
    first_d   = first_q;
    len_d     = len_q;
    rows_d    = rows_q;
    k_d       = k_q;
    mask_d    = mask_q;
    unr_d     = 1'b0;
    done_d    = 1'b0;
    stage_clr = 1'b0;
    wr_en     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          first_d   = first;
          len_d     = span;
          mask_d    = span_mask;
          stage_clr = 1'b1;
          if (rows == '0) begin
            done_d = 1'b1;
          end else begin
            rows_d  = rows;
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (upd_evt) begin
          if (row_full) begin
            state_d = ST_BURST;
            k_d     = '0;
          end else begin
            unr_d = 1'b1;
          end
        end
      end
      ST_BURST: begin
        wr_en = 1'b1;
        if ({1'b0, k_q} == len_q - LW'(1)) begin
          stage_clr = 1'b1;
          rows_d    = rows_q - RW'(1);
          if (rows_q == RW'(1)) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_WAIT;
          end
        end else begin
          k_d = k_q + CW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      first_q <= '0;
      len_q   <= '0;
      rows_q  <= '0;
      k_q     <= '0;
      mask_q  <= '0;
      unr_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      first_q <= first_d;
      len_q   <= len_d;
      rows_q  <= rows_d;
      k_q     <= k_d;
      mask_q  <= mask_d;
      unr_q   <= unr_d;
      done_q  <= done_d;
    end
  end

  assign accept_en = (state_q == ST_WAIT);
  assign row_len   = len_q;
  assign wr_lane   = first_q + k_q;
  assign wr_idx    = k_q;
  assign ch_mask   = mask_q;
  assign xfer_en   = (state_q != ST_IDLE);
  assign underrun  = unr_q;
  assign done      = done_q;
endmodule

// File: rtl/cbl_preload_bank.sv
`timescale 1ns/1ps
module cbl_preload_bank #(
  parameter int NCH = 4,
  parameter int DW  = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CW-1:0]   wr_lane,
  input  logic [DW-1:0]   wr_data,
  input  logic            upd_evt,
  output logic [NCH-1:0]  pre_we,
  output logic [NCH*DW-1:0] cmp_active
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] pre_q;
    logic [DW-1:0] act_q;
    logic          hit;

    assign hit       = wr_en && (wr_lane == CW'(c));
    assign pre_we[c] = hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pre_q <= '0;
      else if (hit) pre_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       act_q <= '0;
      else if (upd_evt) act_q <= pre_q;
    end

    assign cmp_active[c*DW +: DW] = act_q;
  end
endmodule

// File: rtl/cbl_burst_loader.sv
`timescale 1ns/1ps
module cbl_burst_loader #(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int RW  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          seq_start,
  input  logic [RW-1:0]                 seq_rows,
  input  logic [$clog2(NCH)-1:0]        ch_first,
  input  logic [$clog2(NCH)-1:0]        ch_last,
  input  logic                          upd_evt,
  input  logic                          s_valid,
  input  logic [DW-1:0]                 s_data,
  output logic                          s_ready,
  output logic [NCH-1:0]                pre_we,
  output logic [DW-1:0]                 pre_wdata,
  output logic [NCH*DW-1:0]             cmp_active,
  output logic [NCH-1:0]                ch_enable,
  output logic                          xfer_en,
  output logic                          underrun,
  output logic                          done
);
  localparam int CW = $clog2(NCH);
  localparam int LW = CW + 1;

  logic          accept_en;
  logic          stage_clr;
  logic [LW-1:0] row_len;
  logic          row_full;
  logic          wr_en;
  logic [CW-1:0] wr_lane;
  logic [CW-1:0] wr_idx;
  logic [DW-1:0] rd_word;

  cbl_burst_seq #(.NCH(NCH), .RW(RW)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (seq_start),
    .rows      (seq_rows),
    .first     (ch_first),
    .last      (ch_last),
    .upd_evt   (upd_evt),
    .row_full  (row_full),
    .accept_en (accept_en),
    .stage_clr (stage_clr),
    .row_len   (row_len),
    .wr_en     (wr_en),
    .wr_lane   (wr_lane),
    .wr_idx    (wr_idx),
    .ch_mask   (ch_enable),
    .xfer_en   (xfer_en),
    .underrun  (underrun),
    .done      (done)
  );

  cbl_row_stage #(.NCH(NCH), .DW(DW)) stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (stage_clr),
    .accept_en (accept_en),
    .row_len   (row_len),
    .s_valid   (s_valid),
    .s_data    (s_data),
    .s_ready   (s_ready),
    .row_full  (row_full),
    .rd_idx    (wr_idx),
    .rd_word   (rd_word)
  );

  cbl_preload_bank #(.NCH(NCH), .DW(DW)) bank_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_lane    (wr_lane),
    .wr_data    (rd_word),
    .upd_evt    (upd_evt),
    .pre_we     (pre_we),
    .cmp_active (cmp_active)
  );

  assign pre_wdata = rd_word;
endmodule

// File: rtl/cbl_burst_loader_chk.sv
`timescale 1ns/1ps
module cbl_burst_loader_chk #(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_evt,
  input logic              s_ready,
  input logic              xfer_en,
  input logic [NCH-1:0]    pre_we,
  input logic [NCH*DW-1:0] cmp_active,
  input logic              underrun,
  input logic              done
);
  a_r9_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pre_we));

  a_r5_write_needs_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_we != '0) |-> xfer_en);

  a_r4_ready_needs_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |-> !s_ready);

  a_r6_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(cmp_active));

  a_r7_underrun_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (pre_we == '0));

  a_r7_underrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!xfer_en && !s_ready));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind cbl_burst_loader cbl_burst_loader_chk #(.NCH(NCH), .DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_evt    (upd_evt),
  .s_ready    (s_ready),
  .xfer_en    (xfer_en),
  .pre_we     (pre_we),
  .cmp_active (cmp_active),
  .underrun   (underrun),
  .done       (done)
);

// File: tb/cbl_burst_loader_tb_top.sv
`timescale 1ns/1ps
module cbl_burst_loader_tb_top;
  localparam int NCH = 4;
  localparam int DW  = 16;
  localparam int RW  = 16;

  logic              clk;
  logic              rst_n;
  logic              seq_start;
  logic [RW-1:0]     seq_rows;
  logic [1:0]        ch_first;
  logic [1:0]        ch_last;
  logic              upd_evt;
  logic              s_valid;
  logic [DW-1:0]     s_data;
  logic              s_ready;
  logic [NCH-1:0]    pre_we;
  logic [DW-1:0]     pre_wdata;
  logic [NCH*DW-1:0] cmp_active;
  logic [NCH-1:0]    ch_enable;
  logic              xfer_en;
  logic              underrun;
  logic              done;

  int n_chk;
  int n_fail;
  int log_n;
  int log_ch [16];
  logic [DW-1:0] log_d [16];
  int done_n;
  int unr_n;
  int multi_n;

  cbl_burst_loader #(.NCH(NCH), .DW(DW), .RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .seq_rows(seq_rows),
    .ch_first(ch_first), .ch_last(ch_last), .upd_evt(upd_evt),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .pre_we(pre_we), .pre_wdata(pre_wdata), .cmp_active(cmp_active),
    .ch_enable(ch_enable), .xfer_en(xfer_en), .underrun(underrun), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones(pre_we) > 1) multi_n++;
      for (int c = 0; c < NCH; c++) begin
        if (pre_we[c] && log_n < 16) begin
          log_ch[log_n] = c;
          log_d[log_n]  = pre_wdata;
          log_n++;
        end
      end
      if (done)     done_n++;
      if (underrun) unr_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    log_n = 0; done_n = 0; unr_n = 0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_start(input logic [1:0] f, input logic [1:0] l, input logic [RW-1:0] r);
    ch_first = f; ch_last = l; seq_rows = r; seq_start = 1'b1;
    tick(1);
    seq_start = 1'b0;
  endtask

  task automatic send_word(input logic [DW-1:0] d);
    s_valid = 1'b1; s_data = d;
    while (!s_ready) tick(1);
    tick(1);
    s_valid = 1'b0;
  endtask

  task automatic pulse_upd();
    upd_evt = 1'b1;
    tick(1);
    upd_evt = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; seq_start = 0; seq_rows = 0; ch_first = 0; ch_last = 0;
    upd_evt = 0; s_valid = 0; s_data = 0;
    tick(3);
    chk(!s_ready && pre_we == 0 && !xfer_en && !done && !underrun, "R1 ctrl in reset",
        {s_ready, pre_we, xfer_en, done, underrun}, 0);
    chk(cmp_active == 0 && ch_enable == 0, "R1 data in reset", cmp_active, 0);
    @(negedge clk); rst_n = 1'b1;
    tick(2);
    chk(!s_ready && !xfer_en && ch_enable == 0 && cmp_active == 0, "R1 after release",
        {s_ready, xfer_en, ch_enable}, 0);
  endtask

  // R2 R5 R6 R8 R9: channels 1..3, two rows, restart attempt ignored
  task automatic t_two_rows();
    clr_mon();
    do_start(2'd1, 2'd3, 16'd2);
    chk(ch_enable == 4'b1110 && xfer_en, "R2 mask after start", {ch_enable, xfer_en}, 5'b11101);
    do_start(2'd0, 2'd0, 16'd5);
    chk(ch_enable == 4'b1110, "R2 restart ignored", ch_enable, 4'b1110);
    send_word(16'hA001); send_word(16'hA002); send_word(16'hA003);
    chk(!s_ready, "R4 ready low when row full", s_ready, 0);
    pulse_upd();
    chk(cmp_active == 0, "R6 first update applies old preload", cmp_active, 0);
    tick(5);
    chk(log_n == 3, "R5 burst length", log_n, 3);
    chk(log_ch[0] == 1 && log_ch[1] == 2 && log_ch[2] == 3, "R5 ascending lanes",
        {log_ch[0][3:0], log_ch[1][3:0], log_ch[2][3:0]}, 12'h123);
    chk(log_d[0] == 16'hA001 && log_d[1] == 16'hA002 && log_d[2] == 16'hA003, "R5 data order",
        {log_d[0], log_d[1], log_d[2]}, 48'hA001A002A003);
    chk(cmp_active == 0, "R6 hold without update", cmp_active, 0);
    send_word(16'hB001); send_word(16'hB002); send_word(16'hB003);
    pulse_upd();
    chk(cmp_active == 64'hA003_A002_A001_0000, "R6 row applied on next update",
        cmp_active, 64'hA003_A002_A001_0000);
    tick(5);
    chk(done_n == 1 && !xfer_en && !s_ready, "R8 done after final row",
        {done_n[3:0], xfer_en, s_ready}, 6'b000100);
    chk(log_n == 6 && log_d[5] == 16'hB003, "R5 second burst", {log_n[7:0], log_d[5]}, {8'd6, 16'hB003});
    pulse_upd();
    chk(cmp_active == 64'hB003_B002_B001_0000, "R6 last row and unselected lane",
        cmp_active, 64'hB003_B002_B001_0000);
    chk(multi_n == 0, "R9 single strobe", multi_n, 0);
  endtask

  // R3 R4: reversed range selects the single first channel
  task automatic t_reversed();
    clr_mon();
    do_start(2'd2, 2'd1, 16'd1);
    chk(ch_enable == 4'b0100, "R3 reversed range mask", ch_enable, 4'b0100);
    send_word(16'hC0DE);
    chk(!s_ready, "R3 row of one word", s_ready, 0);
    pulse_upd();
    tick(3);
    chk(log_n == 1 && log_ch[0] == 2 && log_d[0] == 16'hC0DE, "R3 single write lane 2",
        {log_n[3:0], log_ch[0][3:0], log_d[0]}, {4'd1, 4'd2, 16'hC0DE});
    chk(done_n == 1, "R8 done single row", done_n, 1);
  endtask

  // R7: underrun, then word and update in the same cycle
  task automatic t_underrun();
    clr_mon();
    do_start(2'd0, 2'd1, 16'd1);
    send_word(16'hD100);
    pulse_upd();
    tick(2);
    chk(unr_n == 1 && log_n == 0, "R7 underrun no write", {unr_n[7:0], log_n[7:0]}, 16'h0100);
    chk(s_ready, "R7 staged word kept, ready for rest", s_ready, 1);
    s_valid = 1'b1; s_data = 16'hD200; upd_evt = 1'b1;
    tick(1);
    s_valid = 1'b0; upd_evt = 1'b0;
    tick(2);
    chk(unr_n == 2 && log_n == 0, "R7 same-cycle word not counted", {unr_n[7:0], log_n[7:0]}, 16'h0200);
    chk(!s_ready, "R7 row complete after collision", s_ready, 0);
    pulse_upd();
    tick(4);
    chk(log_n == 2 && log_ch[0] == 0 && log_d[0] == 16'hD100 && log_ch[1] == 1 && log_d[1] == 16'hD200,
        "R7 full row written later", {log_d[0], log_d[1]}, {16'hD100, 16'hD200});
    chk(done_n == 1 && unr_n == 2, "R8 done after underrun sequence", done_n, 1);
  endtask

  // R8: zero rows
  task automatic t_zero_rows();
    clr_mon();
    do_start(2'd0, 2'd3, 16'd0);
    chk(done && !xfer_en, "R8 zero rows immediate done", {done, xfer_en}, 2'b10);
    pulse_upd();
    tick(3);
    chk(log_n == 0 && done_n == 1 && !s_ready, "R8 zero rows no writes", {log_n[7:0], done_n[7:0]}, 16'h0001);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; multi_n = 0;
    clr_mon();
    t_reset();
    t_two_rows();
    t_reversed();
    t_underrun();
    t_zero_rows();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule